// File: doc/BRIEF.md
# Serial Transmitter with Break and Preamble Generation

This block serialises characters onto one asynchronous line. Software places a character in a one-entry holding register. When the shifter is free, the block moves the character into the shifter, and the character leaves least significant bit first between a low start bit and a high stop bit. Every bit advances on a one-cycle tick that comes from outside the block. A select input chooses between 8 and 9 data bits per frame.

Besides data, the block produces three line conditions of its own:
- Each rising edge of the enable queues a frame-length run of ones, the preamble.
- A held break request sends back-to-back frame-length runs of zeros.
- After a break ends, the block always sends at least one high bit before the next start bit.

The block drives the line and a separate output-enable. It holds the output-enable while queued traffic remains, even after the enable drops, and releases it only when nothing is left to send. Two status flags report the block's state, each gated to its own interrupt output:
- holding register empty;
- transmission complete, which excludes break, mark and preamble activity.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, and whenever the shifter holds nothing, `txd_o` is 1. Reset leaves `txd_oe_o`=0, `empty_o`=1 and `done_o`=1. Whenever `txd_oe_o` is 0, `txd_o` is 1.
- R2: A data frame is one 0 start bit, then data bits LSB first, then one 1 stop bit. With `nine_bit_i`=0 the data bits are `wr_data_i[7:0]` (10 bits in all, bit 8 ignored). With `nine_bit_i`=1 they are `wr_data_i[8:0]` (11 bits in all).
- R3: Every 0-to-1 transition of `tx_en_i` queues one idle character (all ones, frame length) ahead of any other traffic. This includes a transition made while a frame is still being sent.
- R4: While `brk_i`=1 with the transmitter enabled, the block sends break characters (all zeros, frame length) back to back, so the low run is a whole multiple of the frame length.
- R5: After a break, at least one 1 bit is sent before the next start bit. A character written during the break follows that bit.
- R6: `empty_o` goes to 0 the cycle after a write and returns to 1 when the held character moves into the shifter.
- R7: `done_o` is 1 only while the shifter and the holding register are both empty and no break, mark or preamble is active or pending. A write clears it.
- R8: `empty_irq_o` = `empty_o` AND `empty_ie_i`, and `done_irq_o` = `done_o` AND `done_ie_i`.
- R9: `txd_oe_o` is 1 the cycle after `tx_en_i` is 1. If `tx_en_i` drops while the line is idle and nothing is queued, `txd_oe_o` falls on the next cycle.
- R10: If `tx_en_i` drops during activity, `txd_oe_o` stays 1 until every queued item has been sent (shifter contents, held character, pending break), then falls.
- R11: Line bits advance only on `bit_tick_i`. A character written while the pin is released and the enable is low stays held and is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| tx_en_i | input | 1 | Transmitter enable |
| brk_i | input | 1 | Send-break request |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Character to send |
| empty_ie_i | input | 1 | Interrupt enable for the empty flag |
| done_ie_i | input | 1 | Interrupt enable for the complete flag |
| txd_o | output | 1 | Serial line |
| txd_oe_o | output | 1 | Line output-enable |
| empty_o | output | 1 | Holding register empty |
| done_o | output | 1 | Transmission complete |
| empty_irq_o | output | 1 | Masked empty interrupt |
| done_irq_o | output | 1 | Masked complete interrupt |

## Verification
The hardest situation to reach is an enable that falls and rises again while a frame is still on the line. The second preamble must then be inserted between two data frames without the pin ever being released. The stimulus reaches it in a fixed order:
1. Enable the transmitter and queue one character.
2. Wait for its start bit to appear on the line.
3. Pulse the enable low for a single cycle.
4. Write a second character.

The line record taken at each tick must then show at least ten ones between the first stop bit and the second start bit, with the output-enable high throughout. A similar ordering places a write inside a held break, which exposes the forced high bit between the last break and the next start bit.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DATA,
    SRC_BREAK,
    SRC_IDLE,
    SRC_MARK
  } src_e;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (take_i) empty_q <= 1'b1;
      // a write in the same cycle as a transfer refills the register
      if (wr_i) begin
        data_q  <= wr_data_i;
        empty_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;

  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !empty_o);
  a_r6_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> empty_o);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int FW = 11,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [FW-1:0] vec_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          free_o,
  output logic          txd_o
);
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  // free now, or the last bit ends on this tick
  assign free_o = !busy_o || (tick_i && cnt_q == CW'(1));
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= vec_i;
      cnt_q <= len_i;
    end else if (tick_i && busy_o) begin
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  a_r11_load_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> free_o);
  a_r11_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(sh_q) && $stable(cnt_q)));
endmodule

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl import ser_tx_pkg::*; #(
  parameter int BASE_W = 8,
  localparam int DW = BASE_W + 1,
  localparam int FW = BASE_W + 3,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          brk_i,
  input  logic          nine_i,
  input  logic          wr_i,
  input  logic          empty_i,
  input  logic [DW-1:0] data_i,
  input  logic          free_i,
  input  logic          busy_i,
  output logic          load_o,
  output logic [FW-1:0] vec_o,
  output logic [CW-1:0] len_o,
  output logic          take_o,
  output logic          oe_o,
  output logic          done_o
);
  logic en_q, pre_q, brk_q, mark_q, oe_q, done_q, last_brk_q;
  logic pre_now, brk_now, can_load, pending;
  logic [CW-1:0] frame_len;
  src_e sel;

  assign pre_now   = pre_q | (tx_en_i & ~en_q);
  assign brk_now   = brk_q | (brk_i & tx_en_i);
  assign can_load  = tx_en_i | oe_q;
  assign pending   = pre_now | brk_now | mark_q | ~empty_i;
  assign frame_len = nine_i ? CW'(FW) : CW'(FW - 1);

  // fixed order: preamble, break, post-break mark, data
  always_comb begin
    sel = SRC_NONE;
    if (can_load && free_i) begin
      if (pre_now)       sel = SRC_IDLE;
      else if (brk_now)  sel = SRC_BREAK;
      else if (mark_q)   sel = SRC_MARK;
      else if (!empty_i) sel = SRC_DATA;
    end
  end

  always_comb begin
    vec_o = '1;
    len_o = '0;
    unique case (sel)
      SRC_DATA: begin
        vec_o = nine_i ? {1'b1, data_i, 1'b0}
                       : {2'b11, data_i[BASE_W-1:0], 1'b0};
        len_o = frame_len;
      end
      SRC_BREAK: begin
        vec_o = '0;
        len_o = frame_len;
      end
      SRC_IDLE: begin
        vec_o = '1;
        len_o = frame_len;
      end
      SRC_MARK: begin
        vec_o = '1;
        len_o = CW'(1);
      end
      default: begin
        vec_o = '1;
        len_o = '0;
      end
    endcase
  end

  assign load_o = (sel != SRC_NONE);
  assign take_o = (sel == SRC_DATA);
  assign oe_o   = oe_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      pre_q      <= 1'b0;
      brk_q      <= 1'b0;
      mark_q     <= 1'b0;
      oe_q       <= 1'b0;
      done_q     <= 1'b1;
      last_brk_q <= 1'b0;
    end else begin
      en_q   <= tx_en_i;
      pre_q  <= pre_now & (sel != SRC_IDLE);
      brk_q  <= (brk_i & tx_en_i) | (brk_q & (sel != SRC_BREAK));
      mark_q <= (sel == SRC_BREAK) | (mark_q & (sel != SRC_MARK));
      oe_q   <= tx_en_i | (oe_q & (busy_i | load_o | pending));
      done_q <= ~wr_i & ~busy_i & empty_i & ~load_o & ~pre_now & ~brk_now & ~mark_q;
      if (load_o) last_brk_q <= (sel == SRC_BREAK);
    end
  end

  a_r5_mark_before_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !last_brk_q);
  a_r7_done_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && empty_i));
  a_r9_oe_follows_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> oe_o);
  a_r10_oe_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && busy_i) |=> oe_o);
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int BASE_W = 8,
  localparam int DW = BASE_W + 1,
  localparam int FW = BASE_W + 3,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          tx_en_i,
  input  logic          brk_i,
  input  logic          nine_bit_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          empty_ie_i,
  input  logic          done_ie_i,
  output logic          txd_o,
  output logic          txd_oe_o,
  output logic          empty_o,
  output logic          done_o,
  output logic          empty_irq_o,
  output logic          done_irq_o
);
  logic          take, empty, load, free, busy;
  logic [DW-1:0] held;
  logic [FW-1:0] vec;
  logic [CW-1:0] len;

  ser_tx_hold #(.DW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (held),
    .empty_o   (empty)
  );

  ser_tx_ctrl #(.BASE_W(BASE_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .brk_i   (brk_i),
    .nine_i  (nine_bit_i),
    .wr_i    (wr_i),
    .empty_i (empty),
    .data_i  (held),
    .free_i  (free),
    .busy_i  (busy),
    .load_o  (load),
    .vec_o   (vec),
    .len_o   (len),
    .take_o  (take),
    .oe_o    (txd_oe_o),
    .done_o  (done_o)
  );

  ser_tx_shift #(.FW(FW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bit_tick_i),
    .load_i (load),
    .vec_i  (vec),
    .len_i  (len),
    .busy_o (busy),
    .free_o (free),
    .txd_o  (txd_o)
  );

  assign empty_o     = empty;
  assign empty_irq_o = empty & empty_ie_i;
  assign done_irq_o  = done_o & done_ie_i;

  a_r1_released_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_oe_o |-> txd_o);
endmodule

// File: tb/tb_ser_tx_top.sv
`timescale 1ns/1ps
module tb_ser_tx_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, brk = 1'b0, nine = 1'b0, wr = 1'b0;
  logic [8:0] wdata = '0;
  logic eie = 1'b1, die = 1'b1;
  logic txd, oe, empty, done, eirq, dirq;

  int checks = 0, fails = 0;
  bit tick_en = 1'b1, finished = 1'b0;
  int tcnt = 0;
  logic lg_d [0:1023];
  logic lg_oe [0:1023];
  int lg_n = 0;

  always #2 clk = ~clk;

  ser_tx_top dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .tx_en_i(en), .brk_i(brk),
    .nine_bit_i(nine), .wr_i(wr), .wr_data_i(wdata), .empty_ie_i(eie),
    .done_ie_i(die), .txd_o(txd), .txd_oe_o(oe), .empty_o(empty), .done_o(done),
    .empty_irq_o(eirq), .done_irq_o(dirq)
  );

  // stimulus-side tick every 3 cycles; log the bit each tick consumes
  initial begin
    forever begin
      @(negedge clk);
      if (tick_en) begin
        tcnt = (tcnt == 2) ? 0 : tcnt + 1;
        tick = (tcnt == 0);
      end else tick = 1'b0;
      if (tick && lg_n < 1024) begin
        lg_d[lg_n]  = txd;
        lg_oe[lg_n] = oe;
        lg_n++;
      end
    end
  end

  localparam logic [9:0] VEC [6] = '{10'h0A5, 10'h000, 10'h0FF, 10'h3A5, 10'h300, 10'h13C};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write(input logic [8:0] d);
    @(posedge clk); #1;
    wr = 1'b1; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic wait_done();
    cyc(3);
    for (int k = 0; k < 3000; k++) begin
      if (done) break;
      cyc(1);
    end
    cyc(9);
  endtask

  task automatic decode(input int from, input bit nb9, output int z,
                        output logic [8:0] d, output logic stp);
    int nb;
    nb = nb9 ? 9 : 8;
    z = -1; d = '0; stp = 1'b0;
    for (int k = from; k < lg_n; k++) begin
      if (lg_d[k] === 1'b0) begin
        z = k;
        break;
      end
    end
    if (z >= 0 && z + 1 + nb < lg_n) begin
      for (int k = 0; k < nb; k++) d[k] = lg_d[z + 1 + k];
      stp = lg_d[z + 1 + nb];
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int z, z2, a, l, g;
    logic [8:0] d, d2, exp;
    logic s, s2;
    bit ok;

    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(oe == 1'b0, "R1 oe reset", oe, 0);
    chk(empty == 1'b1, "R1 empty reset", empty, 1);
    chk(done == 1'b1, "R1 done reset", done, 1);
    // R8 masking
    chk(eirq == 1'b1 && dirq == 1'b1, "R8 irq enabled", {eirq, dirq}, 3);
    eie = 1'b0; die = 1'b0; #1;
    chk(eirq == 1'b0 && dirq == 1'b0, "R8 irq masked", {eirq, dirq}, 0);
    eie = 1'b1; die = 1'b1;

    // R2 table of frames, R3 preamble on first enable
    for (int i = 0; i < 6; i++) begin
      nine = VEC[i][9];
      exp  = VEC[i][9] ? VEC[i][8:0] : {1'b0, VEC[i][7:0]};
      cyc(1);
      lg_n = 0;
      if (i == 0) en = 1'b1;
      write(VEC[i][8:0]);
      chk(empty == 1'b0 || i == 0, "R6 empty after write", empty, 0);
      wait_done();
      decode(0, nine, z, d, s);
      chk(d == exp, "R2 data bits", d, exp);
      chk(s == 1'b1, "R2 stop bit", s, 1);
      if (i == 0) chk(z >= 10, "R3 preamble before first frame", z, 10);
      chk(empty == 1'b1 && done == 1'b1, "R7 flags after frame", {empty, done}, 3);
    end
    nine = 1'b0;

    // R9 immediate release when idle
    en = 1'b0;
    cyc(1);
    chk(oe == 1'b0, "R9 release when idle", oe, 0);
    chk(txd == 1'b1, "R1 released line high", txd, 1);

    // R11 write while released is held
    write(9'h055);
    cyc(40);
    chk(empty == 1'b0 && oe == 1'b0 && txd == 1'b1, "R11 held while released",
        {empty, oe, txd}, 1);
    lg_n = 0;
    en = 1'b1;
    wait_done();
    decode(0, 1'b0, z, d, s);
    chk(d == 9'h055 && s == 1'b1, "R11 held data sent on enable", d, 9'h055);
    chk(z >= 10, "R3 preamble ahead of held data", z, 10);

    // R4/R5/R7 break with data written during it
    cyc(3);
    lg_n = 0;
    brk = 1'b1;
    cyc(45);
    chk(done == 1'b0 && empty == 1'b1, "R7 done low during break", {done, empty}, 1);
    write(9'h03C);
    cyc(30);
    brk = 1'b0;
    wait_done();
    a = -1;
    for (int k = 0; k < lg_n; k++) if (lg_d[k] === 1'b0) begin a = k; break; end
    l = 0;
    for (int k = (a < 0 ? lg_n : a); k < lg_n && lg_d[k] === 1'b0; k++) l++;
    chk(l >= 10 && (l % 10) == 0, "R4 break run length", l, 30);
    g = 0;
    for (int k = a + l; k < lg_n && lg_d[k] === 1'b1; k++) g++;
    chk(g >= 1, "R5 mark after break", g, 1);
    decode(a + l, 1'b0, z, d, s);
    chk(d == 9'h03C && s == 1'b1, "R5 data after break", d, 9'h03C);

    // R10 drain with two queued characters, R6 empty while second waits
    cyc(3);
    lg_n = 0;
    write(9'h0A1);
    write(9'h05E);
    en = 1'b0;
    chk(empty == 1'b0, "R6 second char waiting", empty, 0);
    chk(oe == 1'b1, "R10 pin held while queued", oe, 1);
    wait_done();
    decode(0, 1'b0, z, d, s);
    decode(z + 10, 1'b0, z2, d2, s2);
    chk(d == 9'h0A1 && d2 == 9'h05E && s2 == 1'b1, "R10 both drained", d2, 9'h05E);
    ok = 1'b1;
    for (int k = 0; k <= z2 + 9 && k < lg_n; k++) if (lg_oe[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R10 oe held through drain", ok, 1);
    chk(oe == 1'b0, "R10 released after drain", oe, 0);

    // R3 re-enable during a frame queues a preamble
    lg_n = 0;
    en = 1'b1;
    write(9'h081);
    for (int k = 0; k < 500; k++) begin
      if (txd == 1'b0) break;
      cyc(1);
    end
    en = 1'b0;
    cyc(1);
    en = 1'b1;
    write(9'h042);
    wait_done();
    decode(0, 1'b0, z, d, s);
    decode(z + 10, 1'b0, z2, d2, s2);
    chk(d == 9'h081 && d2 == 9'h042, "R3 frames around re-enable", d2, 9'h042);
    chk(z2 - (z + 10) >= 10, "R3 preamble after re-enable", z2 - (z + 10), 10);
    ok = 1'b1;
    for (int k = z; k <= z2 + 9 && k < lg_n; k++) if (lg_oe[k] !== 1'b1) ok = 1'b0;
    chk(ok, "R9 pin kept across re-enable", ok, 1);

    // R11 no advance without ticks; R8 empty irq follows write
    tick_en = 1'b0;
    write(9'h000);
    chk(eirq == 1'b0, "R8 empty irq after write", eirq, 0);
    cyc(3);
    chk(txd == 1'b0, "R11 start bit driven", txd, 0);
    cyc(20);
    chk(txd == 1'b0 && done == 1'b0, "R11 no tick no advance", txd, 0);
    tick_en = 1'b1;
    wait_done();
    chk(done == 1'b1 && dirq == 1'b1, "R8 done irq after frame", dirq, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule